// File: doc/BRIEF.md
# Oversampled Bit Phase Selector

This block recovers serial data from a multi-lane link in which every bit period of each lane arrives as a vector of four samples. The four samples are taken at four evenly spaced clock phases. For each lane the block counts where the data transitions fall between adjacent samples over a fixed window of bit periods. It then steers its sampling point toward the sample that sits farthest from the busiest transition boundary. It emits one recovered bit per bit period with a strobe. It also packs the recovered bits into 10-bit words for a downstream symbol aligner.

Decisions are made independently per lane. They are best trained while the link carries transition-dense blanking symbols. The chosen phase is then held for as long as the link stays up. A phase decision may move by at most one position per window, which damps reaction to jitter. Dropping the link-active input returns every lane to phase 0 and discards the partial training and word state. One cycle of the block's clock stands for one bit period, and `smp_vld` marks the cycles that carry a sample vector.

Top module: `bit_phase_select`

## Requirements
- R1: For each valid sample vector (bit i of a lane's 4-bit field is the sample at phase i, phase 0 earliest), the lane produces one recovered bit. The bit equals the sample at the lane's selected phase and is presented with `bit_vld` one clock after the vector. The only exception is the case in R6.
- R2: Transitions are counted per boundary over windows of 64 valid vectors. Boundary b (b = 0..2) lies between samples b and b+1 of the same vector. Boundary 3 lies between sample 3 of the previous valid vector and sample 0 of the current one. Boundary 3 is not counted for the first vector after reset or after the link comes up.
- R3: At the end of a window the target phase is (b* + 2) mod 4, where b* is the boundary with the highest count. On a tie the lowest index wins. The new phase applies from the next valid vector.
- R4: The phase moves by at most one step per window. If the target is one ahead of the current phase (mod 4), the phase steps +1. If the target is one behind, the phase steps -1. If the target is opposite, the phase steps +1.
- R5: The phase is held when all four counts of a window are zero or when the target equals the current phase. The phase never changes except at a window end or while the link is down.
- R6: A step from phase 3 to phase 0 withholds the strobe of the next valid vector, so the repeated bit is discarded. A step from phase 0 to phase 3 adds no strobe.
- R7: While `link_up` is low, every lane's phase reads 0 one clock later, no bit or word strobe is produced, and counters, window position and partial words are cleared.
- R8: Strobed bits are grouped ten at a time per lane, with the first bit in word bit 0. `word_vld` pulses one clock after the tenth strobe.
- R9: Lanes are independent. Lane l uses `smp[4l+3:4l]`, `bit_out[l]`, `bit_vld[l]`, `word_out[10l+9:10l]`, `word_vld[l]` and `phase_sel[2l+1:2l]`.
- R10: After reset every phase is 0 and no bit or word strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per bit period |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| link_up | input | 1 | Link active; low clears the per-lane training state |
| smp_vld | input | 1 | The current cycle carries a sample vector for every lane |
| smp | input | 4*LANES | Four phase samples per lane, phase 0 in the lowest bit |
| bit_out | output | LANES | Recovered bit per lane |
| bit_vld | output | LANES | Strobe for `bit_out` per lane |
| word_out | output | 10*LANES | Packed 10-bit word per lane |
| word_vld | output | LANES | Strobe for `word_out` per lane |
| phase_sel | output | 2*LANES | Selected sample phase per lane |

## Verification
The bench drives each lane with data whose bit edges sit at different sample offsets and checks the phase after single windows. A design that jumped straight to the target would show phase 2 where 1 is expected. A design that confused the direction of the wrap would go the wrong way around from 0 to 3. The 3-to-0 crossing is checked by counting strobes. A design that keeps the repeated bit shows one strobe too many and shifts every later word. A run of constant data checks that an all-zero window does not move the phase toward the lowest-index default. A link drop mid-stream must zero the phases and restart word packing, or the words after it come out misaligned.

// File: rtl/bps_pkg.sv
package bps_pkg;
  localparam int BPS_NPH    = 4;   // samples per bit period (power of two)
  localparam int BPS_WIN    = 64;  // valid vectors per evaluation window
  localparam int BPS_WORD_W = 10;  // recovered bits per symbol
  localparam int BPS_LANES  = 3;
endpackage

// File: rtl/bps_edge_count.sv
module bps_edge_count #(
  parameter int NPH = 4,
  parameter int WIN = 64,
  parameter int CW  = $clog2(WIN + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    vld,
  input  logic [NPH-1:0]          smp,
  output logic                    win_done,
  output logic [NPH-1:0][CW-1:0]  cnt_fin
);
  localparam int WW = $clog2(WIN);

  logic [NPH-1:0][CW-1:0] cnt_q;
  logic [NPH-1:0][CW-1:0] cnt_d;
  logic [NPH-1:0]         hit;
  logic [WW-1:0]          wpos_q, wpos_d;
  logic                   last_q, last_d;
  logic                   seen_q, seen_d;

  always_comb begin
    for (int b = 0; b < NPH - 1; b++) hit[b] = smp[b] ^ smp[b+1];
    hit[NPH-1] = seen_q & (last_q ^ smp[0]);
    win_done   = vld && !clr && (wpos_q == WW'(WIN - 1));
    wpos_d = wpos_q;
    last_d = last_q;
    seen_d = seen_q;
    if (clr) begin
      wpos_d = '0;
      seen_d = 1'b0;
    end else if (vld) begin
      wpos_d = win_done ? '0 : wpos_q + WW'(1);
      last_d = smp[NPH-1];
      seen_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wpos_q <= '0;
      last_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      wpos_q <= wpos_d;
      last_q <= last_d;
      seen_q <= seen_d;
    end
  end

  for (genvar b = 0; b < NPH; b++) begin : g_bnd
    always_comb begin
      cnt_fin[b] = cnt_q[b] + CW'(hit[b]);
      cnt_d[b]   = cnt_q[b];
      if (clr)          cnt_d[b] = '0;
      else if (vld)     cnt_d[b] = win_done ? '0 : cnt_fin[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q[b] <= '0;
      else        cnt_q[b] <= cnt_d[b];
    end

    // R2: a partial window never holds more hits than vectors seen
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q[b] <= CW'(WIN - 1));
    // R2: counts restart at every window end
    a_r2_win_restart: assert property (@(posedge clk) disable iff (!rst_n)
      win_done |=> (cnt_q[b] == '0));
  end
endmodule

// File: rtl/bps_phase_pick.sv
module bps_phase_pick #(
  parameter int NPH  = 4,
  parameter int CW   = 7,
  parameter int PH_W = $clog2(NPH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   vld,
  input  logic                   win_done,
  input  logic [NPH-1:0][CW-1:0] cnt_fin,
  output logic [PH_W-1:0]        phase,
  output logic                   drop_pend
);
  logic [PH_W-1:0] phase_q, phase_d;
  logic [PH_W-1:0] best, target, diff;
  logic [CW-1:0]   best_cnt;
  logic            drop_q, drop_d;

  always_comb begin
    best     = '0;
    best_cnt = cnt_fin[0];
    for (int b = 1; b < NPH; b++) begin
      if (cnt_fin[b] > best_cnt) begin
        best_cnt = cnt_fin[b];
        best     = PH_W'(b);
      end
    end
    target  = best + PH_W'(NPH / 2);
    diff    = target - phase_q;
    phase_d = phase_q;
    drop_d  = drop_q;
    if (vld) drop_d = 1'b0;
    if (win_done && (best_cnt != '0) && (diff != '0)) begin
      if (diff == PH_W'(NPH - 1)) begin
        phase_d = phase_q - PH_W'(1);
      end else begin
        phase_d = phase_q + PH_W'(1);
        if (phase_q == PH_W'(NPH - 1)) drop_d = 1'b1;
      end
    end
    if (clr) begin
      phase_d = '0;
      drop_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      drop_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      drop_q  <= drop_d;
    end
  end

  assign phase     = phase_q;
  assign drop_pend = drop_q;

  // R4: one position per step at most
  a_r4_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((phase_q == $past(phase_q)) ||
              (phase_q == $past(phase_q) + PH_W'(1)) ||
              (phase_q == $past(phase_q) - PH_W'(1))));
  // R5: no movement between window ends
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_done && !clr) |=> $stable(phase_q));
  // R6: a forward wrap always leaves a pending drop
  a_r6_wrap_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && (phase_q == PH_W'(NPH - 1))) |=> ((phase_q != '0) || drop_q));
  // R7: link drop clears the decision
  a_r7_link_clr: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ((phase_q == '0) && !drop_q));
endmodule

// File: rtl/bps_word_pack.sv
module bps_word_pack #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              bvld,
  input  logic              bin,
  output logic [WORD_W-1:0] word,
  output logic              word_vld
);
  localparam int NW = $clog2(WORD_W);

  logic [WORD_W-1:0] sh_q, sh_d, word_q, word_d;
  logic [NW-1:0]     fill_q, fill_d;
  logic              wv_q, wv_d;

  always_comb begin
    sh_d   = sh_q;
    fill_d = fill_q;
    word_d = word_q;
    wv_d   = 1'b0;
    if (clr) begin
      fill_d = '0;
    end else if (bvld) begin
      sh_d = {bin, sh_q[WORD_W-1:1]};
      if (fill_q == NW'(WORD_W - 1)) begin
        fill_d = '0;
        word_d = sh_d;
        wv_d   = 1'b1;
      end else begin
        fill_d = fill_q + NW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      fill_q <= '0;
      word_q <= '0;
      wv_q   <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      fill_q <= fill_d;
      word_q <= word_d;
      wv_q   <= wv_d;
    end
  end

  assign word     = word_q;
  assign word_vld = wv_q;

  // R8: a word only follows an accepted bit
  a_r8_word_src: assert property (@(posedge clk) disable iff (!rst_n)
    wv_q |-> $past(bvld));
endmodule

// File: rtl/bps_lane.sv
module bps_lane #(
  parameter int NPH    = 4,
  parameter int WIN    = 64,
  parameter int WORD_W = 10,
  parameter int PH_W   = $clog2(NPH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_up,
  input  logic              vld,
  input  logic [NPH-1:0]    smp,
  output logic              bit_out,
  output logic              bit_vld,
  output logic [WORD_W-1:0] word,
  output logic              word_vld,
  output logic [PH_W-1:0]   phase
);
  localparam int CW = $clog2(WIN + 1);

  logic                   clr;
  logic                   win_done;
  logic [NPH-1:0][CW-1:0] cnt_fin;
  logic                   drop_pend;
  logic                   bit_q, bit_d, bv_q, bv_d;

  assign clr = ~link_up;

  bps_edge_count #(.NPH(NPH), .WIN(WIN), .CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .vld(vld), .smp(smp),
    .win_done(win_done), .cnt_fin(cnt_fin)
  );

  bps_phase_pick #(.NPH(NPH), .CW(CW), .PH_W(PH_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .clr(clr), .vld(vld), .win_done(win_done),
    .cnt_fin(cnt_fin), .phase(phase), .drop_pend(drop_pend)
  );

  always_comb begin
    bit_d = bit_q;
    bv_d  = 1'b0;
    if (vld && !clr) begin
      bit_d = smp[phase];
      bv_d  = !drop_pend;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= 1'b0;
      bv_q  <= 1'b0;
    end else begin
      bit_q <= bit_d;
      bv_q  <= bv_d;
    end
  end

  assign bit_out = bit_q;
  assign bit_vld = bv_q;

  bps_word_pack #(.WORD_W(WORD_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .clr(clr), .bvld(bv_q), .bin(bit_q),
    .word(word), .word_vld(word_vld)
  );

  // R1: every strobe comes from a vector accepted with the link up
  a_r1_strobe_src: assert property (@(posedge clk) disable iff (!rst_n)
    bv_q |-> ($past(vld) && $past(link_up)));
endmodule

// File: rtl/bit_phase_select.sv
module bit_phase_select
  import bps_pkg::*;
#(
  parameter int LANES  = BPS_LANES,
  parameter int NPH    = BPS_NPH,
  parameter int WIN    = BPS_WIN,
  parameter int WORD_W = BPS_WORD_W,
  parameter int PH_W   = $clog2(NPH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      link_up,
  input  logic                      smp_vld,
  input  logic [LANES*NPH-1:0]      smp,
  output logic [LANES-1:0]          bit_out,
  output logic [LANES-1:0]          bit_vld,
  output logic [LANES*WORD_W-1:0]   word_out,
  output logic [LANES-1:0]          word_vld,
  output logic [LANES*PH_W-1:0]     phase_sel
);
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    bps_lane #(.NPH(NPH), .WIN(WIN), .WORD_W(WORD_W), .PH_W(PH_W)) u_lane (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .link_up (link_up),
      .vld     (smp_vld),
      .smp     (smp[l*NPH +: NPH]),
      .bit_out (bit_out[l]),
      .bit_vld (bit_vld[l]),
      .word    (word_out[l*WORD_W +: WORD_W]),
      .word_vld(word_vld[l]),
      .phase   (phase_sel[l*PH_W +: PH_W])
    );
  end
endmodule

// File: tb/bit_phase_select_test.sv
module bit_phase_select_test;
  localparam int L = 3, NP = 4, WIN = 64, WW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_up = 1'b0;
  logic smp_vld = 1'b0;
  logic [L*NP-1:0] smp = '0;
  logic [L-1:0]    bit_out, bit_vld, word_vld;
  logic [L*WW-1:0] word_out;
  logic [L*2-1:0]  phase_sel;

  bit_phase_select uut (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .smp_vld(smp_vld), .smp(smp),
    .bit_out(bit_out), .bit_vld(bit_vld), .word_out(word_out),
    .word_vld(word_vld), .phase_sel(phase_sel)
  );

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  logic       qb[L][$];
  logic [9:0] qw[L][$];
  int  m_ph[L];
  int  m_cnt[L][NP];
  int  m_wc;
  bit  m_hp[L], m_pl[L], m_drop[L];
  int  strobes[L];
  int  vec_n;
  logic [9:0] part_w[L];
  int  part_n[L];

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic dbit(int pat, int lane, int k);
    if (pat == 0) return 1'b0;
    if (pat == 1) return k[0];
    return ((((k * 13) + (lane * 5)) ^ (k >> 1)) & 1) != 0;
  endfunction

  task automatic model_clear();
    m_wc = 0;
    for (int l = 0; l < L; l++) begin
      m_ph[l] = 0; m_hp[l] = 0; m_pl[l] = 0; m_drop[l] = 0;
      for (int b = 0; b < NP; b++) m_cnt[l][b] = 0;
    end
  endtask

  // scoreboard driver side: expected bits per requirement R1..R6
  task automatic model_push(logic [L*NP-1:0] v);
    for (int l = 0; l < L; l++) begin
      logic [NP-1:0] s;
      s = v[l*NP +: NP];
      if (m_drop[l]) m_drop[l] = 0;
      else qb[l].push_back(s[m_ph[l]]);
      for (int b = 0; b < NP - 1; b++) if (s[b] != s[b+1]) m_cnt[l][b]++;
      if (m_hp[l] && (m_pl[l] != s[NP-1+1-NP])) m_cnt[l][NP-1]++;
      m_pl[l] = s[NP-1];
      m_hp[l] = 1;
    end
    if (m_wc == WIN - 1) begin
      m_wc = 0;
      for (int l = 0; l < L; l++) begin
        int best, tgt, d;
        best = 0;
        for (int b = 1; b < NP; b++) if (m_cnt[l][b] > m_cnt[l][best]) best = b;
        tgt = (best + 2) % NP;
        d   = (tgt - m_ph[l] + NP) % NP;
        if (m_cnt[l][best] != 0 && d != 0) begin
          if (d == NP - 1) m_ph[l] = (m_ph[l] + NP - 1) % NP;
          else begin
            if (m_ph[l] == NP - 1) m_drop[l] = 1;
            m_ph[l] = (m_ph[l] + 1) % NP;
          end
        end
        for (int b = 0; b < NP; b++) m_cnt[l][b] = 0;
      end
    end else m_wc++;
  endtask

  task automatic send(int n, int p0, int p1, int p2, int o0, int o1, int o2);
    int pat[L];
    int off[L];
    pat = '{p0, p1, p2};
    off = '{o0, o1, o2};
    for (int j = 0; j < n; j++) begin
      logic [L*NP-1:0] v;
      for (int l = 0; l < L; l++)
        for (int i = 0; i < NP; i++)
          v[l*NP+i] = dbit(pat[l], l, (4 * vec_n + i - off[l]) / 4);
      @(posedge clk); #5;
      smp = v;
      smp_vld = 1'b1;
      model_push(v);
      vec_n++;
    end
    @(posedge clk); #5;
    smp_vld = 1'b0;
  endtask

  task automatic check_phases(int e0, int e1, int e2, string req);
    int e[L];
    e = '{e0, e1, e2};
    for (int l = 0; l < L; l++)
      check(int'(phase_sel[l*2 +: 2]) == e[l], req, int'(phase_sel[l*2 +: 2]), e[l]);
  endtask

  // scoreboard monitor side
  initial begin
    for (int l = 0; l < L; l++) begin part_n[l] = 0; part_w[l] = '0; strobes[l] = 0; end
    forever begin
      @(posedge clk); #1;
      if (!link_up) for (int l = 0; l < L; l++) part_n[l] = 0;
      for (int l = 0; l < L; l++) begin
        if (word_vld[l] === 1'b1) begin
          if (qw[l].size() == 0) check(0, "R8 unexpected word", 1, 0);
          else begin
            logic [9:0] w;
            w = qw[l].pop_front();
            check(word_out[l*WW +: WW] == w, "R8 word content",
                  int'(word_out[l*WW +: WW]), int'(w));
          end
        end
        if (bit_vld[l] === 1'b1) begin
          strobes[l]++;
          if (qb[l].size() == 0) check(0, "R1 unexpected strobe", 1, 0);
          else begin
            logic b;
            b = qb[l].pop_front();
            check(bit_out[l] == b, "R1 recovered bit", int'(bit_out[l]), int'(b));
            part_w[l][part_n[l]] = b;
            part_n[l]++;
            if (part_n[l] == WW) begin
              qw[l].push_back(part_w[l]);
              part_n[l] = 0;
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s0, s1, s2;
    vec_n = 4;
    model_clear();
    repeat (3) @(posedge clk); #5;
    // R10: reset state
    check_phases(0, 0, 0, "R10 reset phase");
    check(bit_vld == '0, "R10 no bit strobe in reset", int'(bit_vld), 0);
    check(word_vld == '0, "R10 no word strobe in reset", int'(word_vld), 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk); #5;
    link_up = 1'b1;
    @(posedge clk); #5;

    // alternating data, edges at offsets 1,2,0 -> targets 2,3,1
    send(64, 1, 1, 1, 1, 2, 0);
    check_phases(1, 3, 1, "R4 single step after first window (R9 per lane)");
    send(128, 1, 1, 1, 1, 2, 0);
    check_phases(2, 3, 1, "R3 target reached and held");

    // lane0 target 0 from 2: opposite -> +1, then 3->0 wrap drops a strobe
    s0 = strobes[0]; s1 = strobes[1]; s2 = strobes[2];
    send(129, 1, 1, 1, 3, 2, 1);
    check_phases(0, 3, 2, "R6 forward wrap and R5 hold at target");
    check(strobes[0] - s0 == 128, "R6 strobe withheld after 3->0", strobes[0] - s0, 128);
    check(strobes[1] - s1 == 129, "R9 other lane keeps every strobe", strobes[1] - s1, 129);
    check(strobes[2] - s2 == 129, "R1 one strobe per vector", strobes[2] - s2, 129);

    // link drop
    link_up = 1'b0;
    @(posedge clk); #5;
    check_phases(0, 0, 0, "R7 phase cleared on link drop");
    check(bit_vld == '0, "R7 no strobe while link down", int'(bit_vld), 0);
    smp = '1; smp_vld = 1'b1;
    @(posedge clk); #5;
    check(bit_vld == '0, "R7 vector ignored while link down", int'(bit_vld), 0);
    check(word_vld == '0, "R7 no word while link down", int'(word_vld), 0);
    smp_vld = 1'b0;
    model_clear();
    link_up = 1'b1;
    @(posedge clk); #5;

    // constant data: all-zero counts must hold phase
    send(65, 0, 0, 0, 0, 0, 0);
    check_phases(0, 0, 0, "R5 hold on empty window");

    // scrambled data: lane0 target 3 (backward from 0), lane1 target 0, lane2 target 1
    s0 = strobes[0];
    send(128, 2, 2, 2, 2, 3, 0);
    check_phases(3, 0, 1, "R4 backward step across wrap and R2 boundary 3");
    check(strobes[0] - s0 == 128, "R6 no extra strobe on 0->3", strobes[0] - s0, 128);

    repeat (4) @(posedge clk); #5;
    for (int l = 0; l < L; l++) begin
      check(qb[l].size() == 0, "R1 all expected bits seen", qb[l].size(), 0);
      check(qw[l].size() == 0, "R8 all expected words seen", qw[l].size(), 0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule